// File: doc/BRIEF.md
# Bus Cycle Protect Detector

This block watches the address strobe of a shared bus and gives the bus arbiter two flags. `busActive` reports that a bus cycle is in progress, so the arbiter issues no new grant while it is high. `cycleProtect` marks the first external cycle after the bus has been quiet. While it is high, the master that owns that cycle must not lose its grant partway through the cycle. The strobe is sampled on the falling edge of the system clock, and every flop in the block uses that edge.

The block treats the bus as quiet once it has seen a run of `IDLE_SAMPLES` consecutive low strobe samples. Reset counts as quiet as well. The first high sample after a quiet run raises `cycleProtect`, and the flag stays up until the strobe is next sampled low. If the strobe goes low for fewer than `IDLE_SAMPLES` samples between two high runs, the next high run is a back-to-back cycle and does not raise protection again.

Top module: `bus_cycle_protect`

## Requirements
- R1: While `rstN` is low, `busActive` and `cycleProtect` are both 0. After reset the bus counts as quiet.
- R2: After each falling clock edge, `busActive` equals the value of `addrStrobe` sampled at that edge.
- R3: `cycleProtect` goes to 1 at a falling edge where `addrStrobe` is sampled 1, when the samples before it were at least `IDLE_SAMPLES` consecutive 0s, or when no 1 has been sampled since reset.
- R4: Once set, `cycleProtect` stays 1 at every falling edge where `addrStrobe` is still sampled 1.
- R5: `cycleProtect` returns to 0 at the first falling edge where `addrStrobe` is sampled 0.
- R6: A high strobe sample that follows a run of 1 to `IDLE_SAMPLES`-1 zero samples, where a high sample came before that run, leaves `cycleProtect` at 0.
- R7: `cycleProtect` is never 1 while `busActive` is 0. It rises only when `busActive` was 0 at the sample before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its falling edge samples the strobe |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobe | input | 1 | Shared-bus address strobe, 1 while a cycle runs |
| busActive | output | 1 | Bus cycle in progress (registered strobe sample) |
| cycleProtect | output | 1 | First external cycle after a quiet bus; degranting is not allowed |

## Verification
Both outputs are registered at the same falling edge that samples the strobe. Each result is therefore due one falling edge after the strobe value is applied, with no extra latency for protection. The bench changes the strobe half a period before the falling edge and reads both outputs one time unit after that edge. It compares them with a reference model that advances exactly once per edge. Directed gaps one sample shorter than `IDLE_SAMPLES`, and gaps exactly `IDLE_SAMPLES` long, pin down the threshold from both sides. A reset asserted mid-cycle shows that the bus counts as quiet again after reset.

// File: rtl/busprot_pkg.sv
package busprot_pkg;

  // Phase of the bus as seen by the strobe sampler
  typedef enum logic [1:0] {
    PH_ARMED = 2'd0,  // quiet long enough; next cycle is protected
    PH_PROT  = 2'd1,  // inside the protected cycle
    PH_RUN   = 2'd2,  // inside an unprotected cycle
    PH_GAP   = 2'd3   // strobe low, quiet run not yet long enough
  } busPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrLow;  // high sample: restart the quiet-run count
    logic incLow;  // low sample: extend the quiet-run count
  } ctlStrobes_t;

endpackage

// File: rtl/busprot_datapath.sv
module busprot_datapath
  import busprot_pkg::*;
#(
  parameter int IDLE_SAMPLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrobe,
  input  ctlStrobes_t ctl,
  output logic        activeQ,
  output logic        idleReached
);

  localparam int CNT_W = (IDLE_SAMPLES < 2) ? 1 : $clog2(IDLE_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_SAMPLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_SAMPLES - 1);

  logic [CNT_W-1:0] lowCnt;

  // Activity flag: the strobe as seen at the latest falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= addrStrobe;
  end

  // Consecutive low-sample counter, saturating at the threshold
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (ctl.clrLow) begin
      lowCnt <= '0;
    end else if (ctl.incLow && (lowCnt != CNT_MAX)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // The low sample now being taken completes a quiet run
  assign idleReached = (lowCnt >= CNT_LAST);

  assert_active_tracks_R2: assert property (
    @(negedge clk) disable iff (!rstN)
    1'b1 |=> (activeQ == $past(addrStrobe))
  );

  assert_lowcnt_bounded_R6: assert property (
    @(negedge clk) disable iff (!rstN)
    lowCnt <= CNT_MAX
  );

endmodule

// File: rtl/busprot_control.sv
module busprot_control
  import busprot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrobe,
  input  logic        idleReached,
  input  logic        activeQ,
  output ctlStrobes_t ctl,
  output logic        protQ
);

  busPhase_t phase, phaseNext;

  always_comb begin
    ctl.clrLow = addrStrobe;
    ctl.incLow = !addrStrobe;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_ARMED: if (addrStrobe) phaseNext = PH_PROT;
      PH_PROT,
      PH_RUN:   if (!addrStrobe) phaseNext = idleReached ? PH_ARMED : PH_GAP;
      PH_GAP:   if (addrStrobe) phaseNext = PH_RUN;
                else if (idleReached) phaseNext = PH_ARMED;
      default:  phaseNext = PH_ARMED;
    endcase
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_ARMED;
      protQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      protQ <= (phaseNext == PH_PROT);
    end
  end

  assert_prot_implies_active_R7: assert property (
    @(negedge clk) disable iff (!rstN)
    protQ |-> activeQ
  );

  assert_prot_rises_after_quiet_R7: assert property (
    @(negedge clk) disable iff (!rstN)
    $rose(protQ) |-> !$past(activeQ)
  );

  assert_prot_holds_R4: assert property (
    @(negedge clk) disable iff (!rstN)
    (protQ && addrStrobe) |=> protQ
  );

  assert_prot_drops_R5: assert property (
    @(negedge clk) disable iff (!rstN)
    !addrStrobe |=> !protQ
  );

endmodule

// File: rtl/bus_cycle_protect.sv
module bus_cycle_protect
  import busprot_pkg::*;
#(
  parameter int IDLE_SAMPLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrStrobe,
  output logic busActive,
  output logic cycleProtect
);

  ctlStrobes_t ctl;
  logic        activeQ;
  logic        idleReached;
  logic        protQ;

  busprot_datapath #(.IDLE_SAMPLES(IDLE_SAMPLES)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .addrStrobe (addrStrobe),
    .ctl        (ctl),
    .activeQ    (activeQ),
    .idleReached(idleReached)
  );

  busprot_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .addrStrobe (addrStrobe),
    .idleReached(idleReached),
    .activeQ    (activeQ),
    .ctl        (ctl),
    .protQ      (protQ)
  );

  assign busActive    = activeQ;
  assign cycleProtect = protQ;

endmodule

// File: tb/bus_cycle_protect_bench.sv
module bus_cycle_protect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_N     = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrStrobe = 1'b0;
  logic busActive, cycleProtect;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit mArmed = 1'b1;
  int mLow   = 0;
  bit mProt  = 1'b0;
  bit mAct   = 1'b0;

  bus_cycle_protect #(.IDLE_SAMPLES(IDLE_N)) u_bus_cycle_protect (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe),
    .busActive(busActive), .cycleProtect(cycleProtect)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit nextProt(bit s, bit prot, bit armed);
    if (!s) return 1'b0;
    return prot | armed;
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mArmed = 1'b1; mLow = 0; mProt = 1'b0; mAct = 1'b0;
  endtask

  // one sample: drive mid-period, update model, read after the falling edge
  task automatic step(bit s);
    bit prevProt;
    string tag;
    @(posedge clk); #1 addrStrobe = s;
    prevProt = mProt;
    mProt = nextProt(s, mProt, mArmed);
    if (s) begin
      mArmed = 1'b0; mLow = 0;
    end else begin
      mLow++;
      if (mLow >= IDLE_N) mArmed = 1'b1;
    end
    mAct = s;
    @(negedge clk); #1;
    check("R2", busActive, mAct);
    if (mProt && !prevProt)      tag = "R3";
    else if (mProt && prevProt)  tag = "R4";
    else if (!mProt && prevProt) tag = "R5";
    else if (s)                  tag = "R6";
    else                         tag = "R5";
    check(tag, cycleProtect, mProt);
    check("R7", cycleProtect && !busActive, 1'b0);
  endtask

  task automatic doReset();
    @(posedge clk); #1 rstN = 1'b0;
    @(negedge clk); #1;
    check("R1", busActive, 1'b0);
    check("R1", cycleProtect, 1'b0);
    modelReset();
    @(posedge clk); #1 rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #2;
    check("R1", busActive, 1'b0);
    check("R1", cycleProtect, 1'b0);
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;

    // R3: first cycle after reset is protected; R4 hold; R5 drop
    step(1); step(1); step(1); step(0);
    // R6: short gaps (1 and IDLE_N-1 lows) do not re-protect
    step(1); step(0); step(1); step(1);
    for (int i = 0; i < IDLE_N - 1; i++) step(0);
    step(1);
    // R3: exactly IDLE_N lows re-arm protection
    for (int i = 0; i < IDLE_N; i++) step(0);
    step(1); step(1);
    // R1: reset in the middle of a protected cycle, then quiet again
    doReset();
    step(1); step(0);
    // long quiet run then single-sample cycle
    for (int i = 0; i < IDLE_N + 4; i++) step(0);
    step(1); step(0);

    // constrained random: bursty strobe with varied gaps
    for (int i = 0; i < 3000; i++) begin
      int len;
      len = 1 + int'($urandom_range(0, 4));
      for (int j = 0; j < len; j++) step(1);
      len = 1 + int'($urandom_range(0, IDLE_N + 1));
      for (int j = 0; j < len; j++) step(0);
      if ($urandom_range(0, 199) == 0) doReset();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule